// File: doc/BRIEF.md
# Non-nesting Priority Interrupt Controller

This block gathers a set of interrupt request lines (eight by default) and presents at most one of them at a time to a processor. A rising edge on a request line latches a pending bit. A software-loaded mask decides which pending bits may compete. A single global enable flag gates the whole dispatch path. The winning source is the highest-numbered pending, unmasked bit. It is offered as a request line together with its index.

When the processor acknowledges, the controller retires that pending bit and drops the global enable in the same clock. A running handler can therefore never be preempted, even by a more urgent source. Software re-arms the controller with an enable strobe or a return-and-enable strobe. Requests that arrived in the meantime are then offered back to back, most urgent first. A disable strobe lets software shut dispatch off explicitly. The pending, mask and enable state are all visible as outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending bits, the mask and the global enable are all 0, and irq is 0.
- R2: A 0-to-1 transition seen on req_in[i] between two clock edges sets pend_o[i] at the second edge. A line that stays high sets the bit only once; it does not set it again after the bit is cleared.
- R3: irq is 1 exactly when gie_o is 1 and pend_o AND mask_o is non-zero. While irq is 1, irq_idx is the position of the highest set bit of pend_o AND mask_o, where bit 7 is the most urgent and bit 0 the least.
- R4: A request that arrives while gie_o is 0 stays in pend_o, and it is offered on irq once gie_o becomes 1.
- R5: An ack sampled while irq is 1 clears pend_o[irq_idx] and gie_o at the same edge. After that, irq stays 0 until an enable strobe, even if a more urgent request arrives.
- R6: An ack sampled while irq is 0 changes neither pend_o nor gie_o.
- R7: If an edge on req_in[i] and an accepted ack for source i fall in the same cycle, pend_o[i] stays 1.
- R8: ei_stb or reti_stb sets gie_o at the next edge, and di_stb clears it at the next edge. If a clearing cause (di_stb or an accepted ack) meets a setting strobe in the same cycle, gie_o becomes 0.
- R9: mask_we loads mask_wdata into mask_o at the next edge. A pending bit whose mask bit is 0 stays pending but never raises irq.
- R10: Several pending sources are offered one per enable, highest bit first, each after a reti_stb that follows the previous ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | NUM_SRC | Request lines, rising-edge sensitive |
| mask_we | input | 1 | Load strobe for the mask |
| mask_wdata | input | NUM_SRC | New mask value |
| ei_stb | input | 1 | Enable strobe: sets the global enable |
| di_stb | input | 1 | Disable strobe: clears the global enable |
| reti_stb | input | 1 | Return-and-enable strobe: sets the global enable |
| ack | input | 1 | Processor accepts the offered interrupt |
| irq | output | 1 | Interrupt offered to the processor |
| irq_idx | output | IDX_W | Index of the offered source |
| pend_o | output | NUM_SRC | Pending bits |
| mask_o | output | NUM_SRC | Current mask |
| gie_o | output | 1 | Global enable flag |

## Verification
A pending bit that is lost or set twice appears on pend_o one edge after the offending edge. It then leads to a handler that is skipped or repeated on the next return-and-enable. A global enable that fails to drop on acknowledge shows as irq staying high in the cycle right after ack, which is exactly the nesting this block forbids. A faulty priority pick gives a wrong irq_idx as soon as two unmasked bits are pending together, so the tests always present several sources at once.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  // Action applied to the global enable flag at the next edge
  typedef enum logic [1:0] {
    GE_HOLD = 2'd0,
    GE_SET  = 2'd1,
    GE_CLR  = 2'd2
  } ge_op_e;
endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] lines,
  output logic [NUM_SRC-1:0] rise
);
  logic [NUM_SRC-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lines;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_edge
    assign rise[g] = lines[g] & ~prev_q[g];
  end
endmodule

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic [NUM_SRC-1:0] clr_vec,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)             pend[g] <= 1'b0;
      else if (set_vec[g]) pend[g] <= 1'b1;   // set beats clear
      else if (clr_vec[g]) pend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_SRC-1:0] cand,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);   // later (higher) bits overwrite earlier ones
      end
    end
  end
endmodule

// File: rtl/prio_irq_gen.sv
module prio_irq_gen
  import prio_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ge_op_e op,
  output logic   gie
);
  always_ff @(posedge clk) begin
    if (rst) gie <= 1'b0;
    else begin
      case (op)
        GE_SET:  gie <= 1'b1;
        GE_CLR:  gie <= 1'b0;
        default: gie <= gie;
      endcase
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               mask_we,
  input  logic [NUM_SRC-1:0] mask_wdata,
  input  logic               ei_stb,
  input  logic               di_stb,
  input  logic               reti_stb,
  input  logic               ack,
  output logic               irq,
  output logic [IDX_W-1:0]   irq_idx,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               gie_o
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pend;
  logic               any;
  logic [IDX_W-1:0]   win;
  logic               gie;
  logic               take;
  ge_op_e             op;

  prio_irq_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk(clk), .rst(rst), .lines(req_in), .rise(rise)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  prio_irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .cand(pend & mask_q), .any(any), .idx(win)
  );

  assign irq  = gie & any;
  assign take = ack & irq;

  always_comb begin
    clr_vec = '0;
    if (take) clr_vec[win] = 1'b1;
  end

  prio_irq_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_vec(rise), .clr_vec(clr_vec), .pend(pend)
  );

  // Clearing causes win over setting strobes
  always_comb begin
    if (take || di_stb)          op = GE_CLR;
    else if (ei_stb || reti_stb) op = GE_SET;
    else                         op = GE_HOLD;
  end

  prio_irq_gen u_gen (
    .clk(clk), .rst(rst), .op(op), .gie(gie)
  );

  assign irq_idx = win;
  assign pend_o  = pend;
  assign mask_o  = mask_q;
  assign gie_o   = gie;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               ack,
  input logic               ei_stb,
  input logic               di_stb,
  input logic               reti_stb,
  input logic               irq,
  input logic [IDX_W-1:0]   irq_idx,
  input logic [NUM_SRC-1:0] pend_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic               gie_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_o == '0 && mask_o == '0 && !gie_o));

  // R3
  winner_top_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (gie_o && (((pend_o & mask_o) >> irq_idx) == NUM_SRC'(1))));

  // R5
  ack_disables_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> !gie_o);

  // R5
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (!gie_o && !ei_stb && !reti_stb) |=> !irq);

  // R8
  di_clears_chk: assert property (@(posedge clk) disable iff (rst)
    di_stb |=> !gie_o);

  // R2
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack && irq) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ack(ack), .ei_stb(ei_stb), .di_stb(di_stb),
  .reti_stb(reti_stb), .irq(irq), .irq_idx(irq_idx), .pend_o(pend_o),
  .mask_o(mask_o), .gie_o(gie_o)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_in = '0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         ei_stb = 1'b0, di_stb = 1'b0, reti_stb = 1'b0, ack = 1'b0;
  logic         irq;
  logic [2:0]   irq_idx;
  logic [N-1:0] pend_o, mask_o;
  logic         gie_o;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl #(.NUM_SRC(N)) u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .ei_stb(ei_stb), .di_stb(di_stb),
    .reti_stb(reti_stb), .ack(ack), .irq(irq), .irq_idx(irq_idx),
    .pend_o(pend_o), .mask_o(mask_o), .gie_o(gie_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance one clock; inputs change and outputs are sampled at negedge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobe(input string which);
    case (which)
      "ei":   ei_stb = 1'b1;
      "di":   di_stb = 1'b1;
      "reti": reti_stb = 1'b1;
      default: ack = 1'b1;
    endcase
    step();
    ei_stb = 1'b0; di_stb = 1'b0; reti_stb = 1'b0; ack = 1'b0;
  endtask

  task automatic pulse_req(input int b);
    req_in[b] = 1'b1;
    step();
    req_in[b] = 1'b0;
  endtask

  task automatic load_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_wdata = m;
    step();
    mask_we = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pend", pend_o, 0);
    check("R1 mask", mask_o, 0);
    check("R1 gie", gie_o, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_latch_and_order();
    load_mask(8'hFF);
    check("R9 mask load", mask_o, 8'hFF);
    req_in[2] = 1'b1; req_in[5] = 1'b1;
    step();
    check("R2 edge sets pend", pend_o, 8'h24);
    check("R4 held while disabled", irq, 0);
    strobe("ei");
    check("R8 ei sets gie", gie_o, 1);
    check("R3 irq raised", irq, 1);
    check("R3 highest idx", irq_idx, 5);
    strobe("ack");
    check("R5 pend bit cleared", pend_o, 8'h04);
    check("R5 gie cleared", gie_o, 0);
    pulse_req(7);
    check("R5 urgent latched", pend_o, 8'h84);
    check("R5 no nesting", irq, 0);
    strobe("reti");
    check("R10 first after reti", irq_idx, 7);
    check("R10 irq", irq, 1);
    strobe("ack");
    strobe("reti");
    check("R10 second after reti", irq_idx, 2);
    strobe("ack");
    check("R2 held line no reset", pend_o, 0);
    strobe("reti");
    check("R10 drained", irq, 0);
    check("R8 reti sets gie", gie_o, 1);
    req_in = '0;
    step();
  endtask

  task automatic t_ack_idle();
    strobe("ack");
    check("R6 gie kept", gie_o, 1);
    check("R6 pend kept", pend_o, 0);
  endtask

  task automatic t_mask();
    load_mask(8'h0F);
    pulse_req(6);
    check("R9 masked pending", pend_o, 8'h40);
    check("R9 masked no irq", irq, 0);
    pulse_req(1);
    check("R9 unmasked wins", irq_idx, 1);
    check("R9 irq", irq, 1);
    strobe("ack");
    check("R9 masked remains", pend_o, 8'h40);
    load_mask(8'hFF);
    strobe("reti");
    check("R4 served after enable", irq_idx, 6);
    strobe("ack");
    strobe("ei");
  endtask

  task automatic t_set_wins();
    pulse_req(4);
    check("R7 setup", irq_idx, 4);
    step();
    ack = 1'b1; req_in[4] = 1'b1;
    step();
    ack = 1'b0;
    check("R7 set wins over clear", pend_o, 8'h10);
    check("R7 gie cleared", gie_o, 0);
    req_in[4] = 1'b0;
    strobe("reti");
    strobe("ack");
    check("R7 retired later", pend_o, 0);
  endtask

  task automatic t_disable();
    strobe("ei");
    strobe("di");
    check("R8 di clears", gie_o, 0);
    ei_stb = 1'b1; di_stb = 1'b1;
    step();
    ei_stb = 1'b0; di_stb = 1'b0;
    check("R8 clear wins", gie_o, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_latch_and_order();
    t_ack_idle();
    t_mask();
    t_set_wins();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule